// File: doc/BRIEF.md
# Hierarchical Barrier Counter

This block synchronises a fixed set of participants at a hardware barrier. Each participant raises its arrival line for one cycle when it reaches the barrier. Participants are split into equal, fixed groups. Each group counts its own arrivals in a local counter. When a group has heard from all of its members, it sends one increment to a single parent counter. When the parent counter has heard from every group, the episode is complete.

On completion, every counter is cleared and a shared sense bit flips. Every participant's release line follows that sense bit, so a waiting participant leaves the barrier when its release line differs from the value it saw on arrival. A new episode can start on the cycle after release. An arrival from a participant that already arrived in the current episode is reported on a per-participant error line and is not counted again.

Top module: `combining_barrier`

## Requirements
- R1: Reset is synchronous and active low. After reset, every bit of `release_o` is 0 and every bit of `dup_err_o` is 0.
- R2: Participant i belongs to group i / GROUP_SIZE. A group whose members have all arrived does not release the barrier while any other group is incomplete, however long it waits.
- R3: When every group has completed, all bits of `release_o` change together to the new sense value.
- R4: An arrival driven in cycle t that completes the barrier makes `release_o` change after the clock edge that ends cycle t+1. This is one register stage per tree level, with two levels.
- R5: Several arrivals in the same cycle are all counted, whether they come from one group or from several groups.
- R6: An arrival from a participant that has already arrived in the current episode sets that participant's bit of `dup_err_o` for exactly the one cycle after the edge that samples it. The arrival is not counted toward its group.
- R7: Arrivals driven in the cycle after `release_o` changes count toward the next episode. An arrival driven while the completing episode is still in flight counts as a duplicate.
- R8: The sense bit alternates between episodes (0, then 1, then 0, and so on). It holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arrive_i | input | NUM_PART | One-cycle arrival pulse per participant |
| release_o | output | NUM_PART | Per-participant copy of the barrier sense bit |
| dup_err_o | output | NUM_PART | Per-participant one-cycle duplicate-arrival flag |

## Verification
The barrier is driven with a whole group arriving in one cycle, with two groups arriving together, and with members trickling in one per cycle with the groups in reverse order. These patterns separate same-cycle summing from serial counting and show that completion does not depend on which group finishes first. A long wait after one group has filled separates a correct parent count from premature release. Repeated arrivals, first while an episode is in flight and then inside an open episode, separate the duplicate filter from double counting. Arrivals in the cycle right after release separate correct clearing from lost or leftover state.

// File: rtl/cbar_pkg.sv
// Shared helpers for the hierarchical barrier.
// Assumes counts fit in 32 bits.
package cbar_pkg;
    // Width of a counter that must hold values 0..n.
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/cbar_group.sv
// Leaf level of the barrier tree. It counts fresh arrivals of GROUP_SIZE
// members and pulses done_o for one cycle when all of them have arrived.
// Assumes clear_i arrives only after this group has reported done.
module cbar_group
    import cbar_pkg::*;
#(
    parameter int GROUP_SIZE = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GROUP_SIZE-1:0] arrive_i,
    input  logic                  clear_i,
    output logic                  done_o,
    output logic [GROUP_SIZE-1:0] dup_o
);
    localparam int CW = cnt_w(GROUP_SIZE);

    logic [CW-1:0]         cnt_q;
    logic [GROUP_SIZE-1:0] seen_q;
    logic [GROUP_SIZE-1:0] fresh_c;
    logic [CW:0]           sum_c;
    logic                  full_c;
    logic                  done_q;
    logic [GROUP_SIZE-1:0] dup_q;

    // Filter repeats and add this cycle's fresh arrivals to the count.
    always_comb begin
        fresh_c = arrive_i & ~seen_q;
        sum_c   = {1'b0, cnt_q};
        for (int i = 0; i < GROUP_SIZE; i++) begin
            sum_c = sum_c + (CW+1)'(fresh_c[i]);
        end
        full_c = (sum_c == (CW+1)'(GROUP_SIZE));
    end

    // Update count, arrival record, done pulse and duplicate flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= '0;
            done_q <= 1'b0;
            dup_q  <= '0;
        end else begin
            done_q <= full_c;
            dup_q  <= arrive_i & seen_q;
            cnt_q  <= full_c ? '0 : sum_c[CW-1:0];
            seen_q <= clear_i ? '0 : (seen_q | fresh_c);
        end
    end

    assign done_o = done_q;
    assign dup_o  = dup_q;

    p_cnt_below_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(GROUP_SIZE));

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    p_repeat_not_counted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((arrive_i & ~seen_q) == '0) |=> $stable(cnt_q));

    p_record_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (seen_q == '0));
endmodule

// File: rtl/cbar_root.sv
// Top level of the barrier tree. It counts group-done pulses. When every
// group has reported, it flips the sense bit and raises fire_o for the
// same cycle so that the leaves clear their arrival records.
// Assumes each group pulses at most once per episode.
module cbar_root
    import cbar_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] group_done_i,
    output logic                  fire_o,
    output logic                  sense_o
);
    localparam int RW = cnt_w(NUM_GROUPS);

    logic [RW-1:0] rcnt_q;
    logic [RW:0]   rsum_c;
    logic          fire_c;
    logic          sense_q;

    // Add the group pulses of this cycle and detect completion.
    always_comb begin
        rsum_c = {1'b0, rcnt_q};
        for (int g = 0; g < NUM_GROUPS; g++) begin
            rsum_c = rsum_c + (RW+1)'(group_done_i[g]);
        end
        fire_c = (rsum_c == (RW+1)'(NUM_GROUPS));
    end

    // Keep the parent count and flip the sense bit on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q  <= '0;
            sense_q <= 1'b0;
        end else begin
            rcnt_q <= fire_c ? '0 : rsum_c[RW-1:0];
            if (fire_c) begin
                sense_q <= ~sense_q;
            end
        end
    end

    assign fire_o  = fire_c;
    assign sense_o = sense_q;

    p_root_below_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt_q < RW'(NUM_GROUPS));

    p_sense_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_c |=> $stable(sense_q));

    p_sense_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_c |=> (sense_q != $past(sense_q)));
endmodule

// File: rtl/combining_barrier.sv
// Two-level barrier: NUM_PART participants in groups of GROUP_SIZE feed
// per-group counters, and those feed a single parent counter. The release
// lines carry the shared sense bit.
// Assumes NUM_PART is a multiple of GROUP_SIZE.
module combining_barrier #(
    parameter int NUM_PART   = 8,
    parameter int GROUP_SIZE = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] arrive_i,
    output logic [NUM_PART-1:0] release_o,
    output logic [NUM_PART-1:0] dup_err_o
);
    localparam int NUM_GROUPS = NUM_PART / GROUP_SIZE;

    logic [NUM_GROUPS-1:0] grp_done;
    logic                  fire;
    logic                  sense;

    // One leaf counter per group.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_leaf
        cbar_group #(.GROUP_SIZE(GROUP_SIZE)) u_group (
            .clk      (clk),
            .rst_n    (rst_n),
            .arrive_i (arrive_i[g*GROUP_SIZE +: GROUP_SIZE]),
            .clear_i  (fire),
            .done_o   (grp_done[g]),
            .dup_o    (dup_err_o[g*GROUP_SIZE +: GROUP_SIZE])
        );
    end

    cbar_root #(.NUM_GROUPS(NUM_GROUPS)) u_root (
        .clk          (clk),
        .rst_n        (rst_n),
        .group_done_i (grp_done),
        .fire_o       (fire),
        .sense_o      (sense)
    );

    // Broadcast the sense bit to every participant.
    assign release_o = {NUM_PART{sense}};

    p_release_moves_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(release_o));
endmodule

// File: tb/test_combining_barrier.sv
module test_combining_barrier;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int WATCHDOG_CYCLES = 2000;

    typedef struct {
        int          stamp;
        logic        sense;
        logic [NP-1:0] dup;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive = '0;
    logic [NP-1:0] release_o;
    logic [NP-1:0] dup_err_o;

    int   cycle = 0;
    int   checks = 0;
    int   fails = 0;
    exp_t q[$];

    combining_barrier #(.NUM_PART(NP), .GROUP_SIZE(4)) i_combining_barrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .arrive_i  (arrive),
        .release_o (release_o),
        .dup_err_o (dup_err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cycle <= cycle + 1;

    // Driver: apply one cycle of arrivals and queue the result expected after the edge.
    task automatic step(input logic [NP-1:0] arr, input logic exp_sense,
                        input logic [NP-1:0] exp_dup, input string tag);
        exp_t e;
        arrive  = arr;
        e.stamp = cycle + 1;
        e.sense = exp_sense;
        e.dup   = exp_dup;
        e.tag   = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare outputs with the queued expectation of this cycle.
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].stamp == cycle) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (release_o !== {NP{e.sense}} || dup_err_o !== e.dup) begin
                fails++;
                $display("FAIL %s: release=%h dup=%h expected release=%h dup=%h",
                         e.tag, release_o, dup_err_o, {NP{e.sense}}, e.dup);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, cycle=%0d expected below %0d",
                 cycle, WATCHDOG_CYCLES);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (release_o !== '0 || dup_err_o !== '0) begin
            fails++;
            $display("FAIL R1 reset: release=%h dup=%h expected release=00 dup=00",
                     release_o, dup_err_o);
        end

        // Episode 1: group 0 at once, group 1 in two chunks.
        step(8'h0F, 1'b0, 8'h00, "R5 whole group in one cycle");
        step(8'h00, 1'b0, 8'h00, "R2 one full group does not release");
        step(8'h00, 1'b0, 8'h00, "R2 one full group does not release");
        step(8'h00, 1'b0, 8'h00, "R2 one full group does not release");
        step(8'h30, 1'b0, 8'h00, "R5 partial group");
        step(8'hC0, 1'b0, 8'h00, "R4 no release after one stage");
        step(8'h01, 1'b1, 8'h01, "R3 R4 release after two stages, R7 in-flight repeat is duplicate");
        // Episode 2: everyone in the cycle after release.
        step(8'hFF, 1'b1, 8'h00, "R7 next episode accepted, R5 all groups together");
        step(8'h00, 1'b0, 8'h00, "R8 sense returns to 0");
        step(8'h00, 1'b0, 8'h00, "R8 sense holds");

        // Episode 3: repeated arrivals inside an open episode.
        step(8'h03, 1'b0, 8'h00, "R6 first arrivals");
        step(8'h03, 1'b0, 8'h03, "R6 repeat flagged");
        step(8'hF0, 1'b0, 8'h00, "R6 flag is one cycle");
        step(8'h00, 1'b0, 8'h00, "R6 repeat not counted");
        step(8'h00, 1'b0, 8'h00, "R6 repeat not counted");
        step(8'h00, 1'b0, 8'h00, "R6 repeat not counted");
        step(8'h0C, 1'b0, 8'h00, "R4 last arrival");
        step(8'h00, 1'b1, 8'h00, "R3 R4 release");
        step(8'h00, 1'b1, 8'h00, "R8 sense holds");

        // Episode 4: one member per cycle, upper group first.
        step(8'h80, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h40, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h20, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h10, 1'b1, 8'h00, "R2 upper group full");
        step(8'h01, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h02, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h04, 1'b1, 8'h00, "R2 serial arrival");
        step(8'h08, 1'b1, 8'h00, "R4 last arrival");
        step(8'h00, 1'b0, 8'h00, "R3 R8 release to 0");
        step(8'h00, 1'b0, 8'h00, "R8 sense holds");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule